// File: doc/BRIEF.md
# Instruction Operand-Select Decode Stage

This block is the second decode step for a 32-bit fixed-width instruction. A first-stage table lookup has already classified the opcode and supplies a set of small selector codes and control flags. This stage combines those selectors with the raw instruction word to produce the operand-fetch description the execute side needs. That description covers up to three general-register reads, two special-register reads, one special-register write, one general-register write, a 64-bit immediate, and the record (Rc), overflow-enable (OE) and link (LK) bits. Each of these outputs comes with its own enable.

Instruction bits are numbered from the most significant end, so field bit 0 is `insn[31]` and field bit n is `insn[31-n]`. All field positions below use that numbering.

The word and its selectors enter on a valid/ready stream and the decoded bundle leaves on another. `in_ready` is high whenever the output slot is empty or is being drained in the same cycle. A beat is accepted on a clock edge where `in_valid` and `in_ready` are both high. While `out_valid` is high and `out_ready` is low, the presented bundle is held unchanged. A build-time parameter can remove the output register, which makes the stage purely combinational with ready passed straight through.

Top module: `opsel_decode`

## Requirements
- R1: With the output register present, a beat accepted on one edge is presented with `out_valid` high after that edge. Beats leave in the order they entered. While `out_valid` is high and `out_ready` is low, `out_valid` and every bundle output stay unchanged. `in_ready` equals `!out_valid || out_ready`.
- R2: During synchronous reset (`rst_n` low at an edge), `out_valid`, every enable and every bundle field go to zero. Any port or field whose enable is low drives zero.
- R3: Register read port 1 depends on `a_sel` (0 none, 1 RA, 2 RA-or-zero, 3 none). For code 1 it carries RA (field bits 11-15) and is enabled. For code 2 it does the same, unless RA is 0, in which case it is disabled.
- R4: Register read port 2 is enabled and carries RB (field bits 16-20) only when `b_sel` is 1.
- R5: Register read port 3 is enabled and carries RS (field bits 6-10) only when `c_sel` is 1.
- R6: Special read port 1 depends on `op_class` (1 conditional branch, 2 branch to register, 3 move-from-special, 4 move-to-special). For classes 1 and 2 with field bit 8 equal to 0, it is enabled with number `CTR_NUM`. For classes 3 and 4, it is enabled with the raw 10-bit field bits 11-20 (`insn[20:11]`).
- R7: When `b_sel` is 12, special read port 2 is enabled and both the immediate and read port 2 are disabled. Its number is `CTR_NUM` if field bit 21 is 1, and `LR_NUM` otherwise.
- R8: `b_sel` codes 2 to 5 enable the immediate, built from the 16-bit field at bits 16-31. Code 2 zero-extends it. Code 3 sign-extends it. Code 4 shifts it left 16 and zero-extends. Code 5 shifts it left 16 and sign-extends.
- R9: `b_sel` code 6 takes field bits 6-29, and codes 7 and 8 take field bits 16-29. In each case the value is shifted left 2 and then sign-extended to 64 bits.
- R10: `b_sel` code 9 gives all ones. Code 10 gives a 6-bit shift count whose top bit is field bit 30 and whose low five bits are field bits 16-20. Code 11 gives field bits 16-20. Codes 0, 1 and 13-15 leave the immediate disabled.
- R11: The destination depends on `d_sel` (0 none, 1 RT, 2 RA, 3 special). For codes 1 and 2 the register write is enabled and carries field bits 6-10 or 11-15 respectively. For code 3 only the special write is enabled, carrying field bits 11-20. For code 0 neither is enabled.
- R12: Rc is always enabled. Its value depends on `rc_mode`: 0 gives 0, 1 gives 1, 2 gives field bit 31, and 3 gives 0. OE is always enabled and equals field bit 21.
- R13: LK equals field bit 31 when `link_en` is high, and 0 otherwise. `flags_out` repeats `pass_flags` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Stage can take a beat |
| insn | input | 32 | Raw instruction word |
| a_sel | input | 2 | Read port 1 selector |
| b_sel | input | 4 | Second operand selector |
| c_sel | input | 1 | Read port 3 selector |
| d_sel | input | 2 | Destination selector |
| rc_mode | input | 2 | Record bit mode |
| op_class | input | 3 | Operation class from first stage |
| link_en | input | 1 | Operation uses the link bit |
| pass_flags | input | FLAG_W | Control flags forwarded unchanged |
| out_valid | output | 1 | Bundle presented |
| out_ready | input | 1 | Consumer takes the bundle |
| rd1_idx | output | 5 | Read port 1 register |
| rd1_en | output | 1 | Read port 1 enable |
| rd2_idx | output | 5 | Read port 2 register |
| rd2_en | output | 1 | Read port 2 enable |
| rd3_idx | output | 5 | Read port 3 register |
| rd3_en | output | 1 | Read port 3 enable |
| sr1_num | output | 10 | Special read 1 number |
| sr1_en | output | 1 | Special read 1 enable |
| sr2_num | output | 10 | Special read 2 number |
| sr2_en | output | 1 | Special read 2 enable |
| imm | output | XLEN | Immediate operand |
| imm_en | output | 1 | Immediate enable |
| wr_idx | output | 5 | Destination register |
| wr_en | output | 1 | Register write enable |
| sw_num | output | 10 | Special write number |
| sw_en | output | 1 | Special write enable |
| rc_bit | output | 1 | Record bit |
| rc_en | output | 1 | Record bit enable |
| oe_bit | output | 1 | Overflow enable bit |
| oe_en | output | 1 | Overflow enable valid |
| lk_bit | output | 1 | Link bit |
| flags_out | output | FLAG_W | Forwarded flags |

## Verification
The bench aims at RA-or-zero with RA equal to 0, which a careless design would still enable as a read of register 0. It also covers the count/link choice for special read 2 and the bit-8 condition on branches; swapping either picks the wrong special register. The immediates are tested with sign bits both set and clear and with split shift counts: a missing shift, a wrong extension point or swapped halves of the 6-bit count all show up as a bad 64-bit value. The output is stalled at random, which exposes a stage that overwrites or drops a held bundle, or that reorders beats.

// File: rtl/opsel_pkg.sv
package opsel_pkg;

  localparam int unsigned IDX_W = 5;
  localparam int unsigned SPR_W = 10;

  // second operand selector codes
  localparam logic [3:0] B_NONE  = 4'd0;
  localparam logic [3:0] B_RB    = 4'd1;
  localparam logic [3:0] B_UI    = 4'd2;
  localparam logic [3:0] B_SI    = 4'd3;
  localparam logic [3:0] B_UI_HI = 4'd4;
  localparam logic [3:0] B_SI_HI = 4'd5;
  localparam logic [3:0] B_LI    = 4'd6;
  localparam logic [3:0] B_BD    = 4'd7;
  localparam logic [3:0] B_DS    = 4'd8;
  localparam logic [3:0] B_M1    = 4'd9;
  localparam logic [3:0] B_SH    = 4'd10;
  localparam logic [3:0] B_SH32  = 4'd11;
  localparam logic [3:0] B_SPR   = 4'd12;

  typedef enum logic [1:0] {A_NONE = 2'd0, A_RA = 2'd1, A_RA0 = 2'd2} asel_e;
  typedef enum logic [1:0] {D_NONE = 2'd0, D_RT = 2'd1, D_RA = 2'd2, D_SPR = 2'd3} dsel_e;
  typedef enum logic [1:0] {RCM_ZERO = 2'd0, RCM_ONE = 2'd1, RCM_INSN = 2'd2} rcm_e;
  typedef enum logic [2:0] {
    OC_OTHER = 3'd0, OC_BC = 3'd1, OC_BCREG = 3'd2, OC_MFSPR = 3'd3, OC_MTSPR = 3'd4
  } opc_e;

  typedef struct packed {
    logic [IDX_W-1:0] rd1_idx;
    logic             rd1_en;
    logic [IDX_W-1:0] rd2_idx;
    logic             rd2_en;
    logic [IDX_W-1:0] rd3_idx;
    logic             rd3_en;
    logic [SPR_W-1:0] sr1_num;
    logic             sr1_en;
    logic [SPR_W-1:0] sr2_num;
    logic             sr2_en;
    logic [IDX_W-1:0] wr_idx;
    logic             wr_en;
    logic [SPR_W-1:0] sw_num;
    logic             sw_en;
    logic             imm_en;
    logic             rc_bit;
    logic             rc_en;
    logic             oe_bit;
    logic             oe_en;
    logic             lk_bit;
  } port_bundle_t;

endpackage

// File: rtl/opsel_regs.sv
module opsel_regs
  import opsel_pkg::*;
(
  input  logic [31:0]      insn,
  input  logic [1:0]       a_sel,
  input  logic [3:0]       b_sel,
  input  logic             c_sel,
  input  logic [1:0]       d_sel,
  output logic [IDX_W-1:0] rd1_idx,
  output logic             rd1_en,
  output logic [IDX_W-1:0] rd2_idx,
  output logic             rd2_en,
  output logic [IDX_W-1:0] rd3_idx,
  output logic             rd3_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             wr_en,
  output logic [SPR_W-1:0] sw_num,
  output logic             sw_en
);
  // field slices, MSB-first numbering: field bit n is insn[31-n]
  logic [IDX_W-1:0] f_rt, f_ra, f_rb;
  logic [SPR_W-1:0] f_spr;
  assign f_rt  = insn[25:21];
  assign f_ra  = insn[20:16];
  assign f_rb  = insn[15:11];
  assign f_spr = insn[20:11];

  always_comb begin
    rd1_en = 1'b0;
    unique case (asel_e'(a_sel))
      A_RA:    rd1_en = 1'b1;
      A_RA0:   rd1_en = (f_ra != '0);
      default: rd1_en = 1'b0;
    endcase
    rd1_idx = rd1_en ? f_ra : '0;

    rd2_en  = (b_sel == B_RB);
    rd2_idx = rd2_en ? f_rb : '0;
    rd3_en  = c_sel;
    rd3_idx = rd3_en ? f_rt : '0;

    wr_en  = 1'b0;
    wr_idx = '0;
    sw_en  = 1'b0;
    sw_num = '0;
    unique case (dsel_e'(d_sel))
      D_RT:    begin wr_en = 1'b1; wr_idx = f_rt; end
      D_RA:    begin wr_en = 1'b1; wr_idx = f_ra; end
      D_SPR:   begin sw_en = 1'b1; sw_num = f_spr; end
      default: ;
    endcase
  end
endmodule

// File: rtl/opsel_spr.sv
module opsel_spr
  import opsel_pkg::*;
#(
  parameter logic [SPR_W-1:0] CTR_NUM = 10'd9,
  parameter logic [SPR_W-1:0] LR_NUM  = 10'd8
) (
  input  logic [31:0]      insn,
  input  logic [3:0]       b_sel,
  input  logic [2:0]       op_class,
  output logic [SPR_W-1:0] sr1_num,
  output logic             sr1_en,
  output logic [SPR_W-1:0] sr2_num,
  output logic             sr2_en
);
  logic bo_bit8, xo_bit21;
  assign bo_bit8  = insn[23];
  assign xo_bit21 = insn[10];

  always_comb begin
    sr1_en  = 1'b0;
    sr1_num = '0;
    unique case (opc_e'(op_class))
      OC_BC, OC_BCREG: if (!bo_bit8) begin
        sr1_en  = 1'b1;
        sr1_num = CTR_NUM;
      end
      OC_MFSPR, OC_MTSPR: begin
        sr1_en  = 1'b1;
        sr1_num = insn[20:11];
      end
      default: ;
    endcase
    sr2_en  = (b_sel == B_SPR);
    sr2_num = !sr2_en ? '0 : (xo_bit21 ? CTR_NUM : LR_NUM);
  end
endmodule

// File: rtl/opsel_imm.sv
module opsel_imm
  import opsel_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [31:0]     insn,
  input  logic [3:0]      b_sel,
  output logic [XLEN-1:0] imm,
  output logic            imm_en
);
  localparam int unsigned HW = 16;

  logic [HW-1:0] f_half;
  logic          s16, s26;
  assign f_half = insn[15:0];
  assign s16    = insn[15];
  assign s26    = insn[25];

  always_comb begin
    imm_en = 1'b1;
    imm    = '0;
    unique case (b_sel)
      B_UI:    imm = XLEN'(f_half);
      B_SI:    imm = {{(XLEN-HW){s16}}, f_half};
      B_UI_HI: imm = XLEN'({f_half, 16'h0000});
      B_SI_HI: imm = {{(XLEN-2*HW){s16}}, f_half, 16'h0000};
      B_LI:    imm = {{(XLEN-26){s26}}, insn[25:2], 2'b00};
      B_BD, B_DS: imm = {{(XLEN-HW){s16}}, insn[15:2], 2'b00};
      B_M1:    imm = '1;
      B_SH:    imm = XLEN'({insn[1], insn[15:11]});
      B_SH32:  imm = XLEN'(insn[15:11]);
      default: imm_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/opsel_decode.sv
module opsel_decode
  import opsel_pkg::*;
#(
  parameter int unsigned      XLEN       = 64,
  parameter int unsigned      FLAG_W     = 11,
  parameter bit               REGISTERED = 1'b1,
  parameter logic [9:0]       CTR_NUM    = 10'd9,
  parameter logic [9:0]       LR_NUM     = 10'd8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       insn,
  input  logic [1:0]        a_sel,
  input  logic [3:0]        b_sel,
  input  logic              c_sel,
  input  logic [1:0]        d_sel,
  input  logic [1:0]        rc_mode,
  input  logic [2:0]        op_class,
  input  logic              link_en,
  input  logic [FLAG_W-1:0] pass_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [4:0]        rd1_idx,
  output logic              rd1_en,
  output logic [4:0]        rd2_idx,
  output logic              rd2_en,
  output logic [4:0]        rd3_idx,
  output logic              rd3_en,
  output logic [9:0]        sr1_num,
  output logic              sr1_en,
  output logic [9:0]        sr2_num,
  output logic              sr2_en,
  output logic [XLEN-1:0]   imm,
  output logic              imm_en,
  output logic [4:0]        wr_idx,
  output logic              wr_en,
  output logic [9:0]        sw_num,
  output logic              sw_en,
  output logic              rc_bit,
  output logic              rc_en,
  output logic              oe_bit,
  output logic              oe_en,
  output logic              lk_bit,
  output logic [FLAG_W-1:0] flags_out
);
  port_bundle_t      d_b;
  logic [XLEN-1:0]   d_imm;

  opsel_regs u_regs (
    .insn(insn), .a_sel(a_sel), .b_sel(b_sel), .c_sel(c_sel), .d_sel(d_sel),
    .rd1_idx(d_b.rd1_idx), .rd1_en(d_b.rd1_en),
    .rd2_idx(d_b.rd2_idx), .rd2_en(d_b.rd2_en),
    .rd3_idx(d_b.rd3_idx), .rd3_en(d_b.rd3_en),
    .wr_idx(d_b.wr_idx), .wr_en(d_b.wr_en),
    .sw_num(d_b.sw_num), .sw_en(d_b.sw_en)
  );

  opsel_spr #(.CTR_NUM(CTR_NUM), .LR_NUM(LR_NUM)) u_spr (
    .insn(insn), .b_sel(b_sel), .op_class(op_class),
    .sr1_num(d_b.sr1_num), .sr1_en(d_b.sr1_en),
    .sr2_num(d_b.sr2_num), .sr2_en(d_b.sr2_en)
  );

  opsel_imm #(.XLEN(XLEN)) u_imm (
    .insn(insn), .b_sel(b_sel), .imm(d_imm), .imm_en(d_b.imm_en)
  );

  // record, overflow and link bits (field bits 31 and 21)
  always_comb begin
    d_b.rc_en  = 1'b1;
    d_b.oe_en  = 1'b1;
    d_b.oe_bit = insn[10];
    d_b.lk_bit = link_en & insn[0];
    unique case (rcm_e'(rc_mode))
      RCM_ONE:  d_b.rc_bit = 1'b1;
      RCM_INSN: d_b.rc_bit = insn[0];
      default:  d_b.rc_bit = 1'b0;
    endcase
  end

  port_bundle_t      q_b;
  logic [XLEN-1:0]   q_imm;
  logic [FLAG_W-1:0] q_flags;

  generate
    if (REGISTERED) begin : g_reg
      logic q_vld;
      assign in_ready  = !q_vld || out_ready;
      assign out_valid = q_vld;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q_vld   <= 1'b0;
          q_b     <= '0;
          q_imm   <= '0;
          q_flags <= '0;
        end else begin
          if (in_ready) q_vld <= in_valid;
          if (in_valid && in_ready) begin
            q_b     <= d_b;
            q_imm   <= d_imm;
            q_flags <= pass_flags;
          end
        end
      end
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign q_b       = d_b;
      assign q_imm     = d_imm;
      assign q_flags   = pass_flags;
    end
  endgenerate

  assign rd1_idx   = q_b.rd1_idx;
  assign rd1_en    = q_b.rd1_en;
  assign rd2_idx   = q_b.rd2_idx;
  assign rd2_en    = q_b.rd2_en;
  assign rd3_idx   = q_b.rd3_idx;
  assign rd3_en    = q_b.rd3_en;
  assign sr1_num   = q_b.sr1_num;
  assign sr1_en    = q_b.sr1_en;
  assign sr2_num   = q_b.sr2_num;
  assign sr2_en    = q_b.sr2_en;
  assign imm       = q_imm;
  assign imm_en    = q_b.imm_en;
  assign wr_idx    = q_b.wr_idx;
  assign wr_en     = q_b.wr_en;
  assign sw_num    = q_b.sw_num;
  assign sw_en     = q_b.sw_en;
  assign rc_bit    = q_b.rc_bit;
  assign rc_en     = q_b.rc_en;
  assign oe_bit    = q_b.oe_bit;
  assign oe_en     = q_b.oe_en;
  assign lk_bit    = q_b.lk_bit;
  assign flags_out = q_flags;
endmodule

// File: rtl/opsel_decode_chk.sv
module opsel_decode_chk #(
  parameter int unsigned XLEN       = 64,
  parameter bit          REGISTERED = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [31:0]     insn,
  input logic [1:0]      a_sel,
  input logic [3:0]      b_sel,
  input logic            rd1_en,
  input logic            rd2_en,
  input logic            sr2_en,
  input logic            imm_en,
  input logic [XLEN-1:0] imm,
  input logic [4:0]      wr_idx,
  input logic            rc_en,
  input logic            oe_en
);
  // R12
  rc_oe_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (rc_en && oe_en));

  generate
    if (REGISTERED) begin : g_seq
      // R2
      reset_empty_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

      // R1
      accept_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

      // R1
      stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(imm) && $stable(wr_idx)));

      // R3
      ra_zero_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && a_sel == 2'd2 && insn[20:16] == 5'd0) |=> !rd1_en);

      // R7
      spr_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && b_sel == 4'd12) |=> (sr2_en && !imm_en && !rd2_en));
    end
  endgenerate
endmodule

bind opsel_decode opsel_decode_chk #(.XLEN(XLEN), .REGISTERED(REGISTERED)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .insn(insn), .a_sel(a_sel),
  .b_sel(b_sel), .rd1_en(rd1_en), .rd2_en(rd2_en), .sr2_en(sr2_en),
  .imm_en(imm_en), .imm(imm), .wr_idx(wr_idx), .rc_en(rc_en), .oe_en(oe_en)
);

// File: tb/opsel_decode_bench.sv
`timescale 1ns/1ps
module opsel_decode_bench;
  localparam int FW = 11;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [31:0] insn = '0;
  logic [1:0] a_sel = '0, d_sel = '0, rc_mode = '0;
  logic [3:0] b_sel = '0;
  logic c_sel = 1'b0, link_en = 1'b0;
  logic [2:0] op_class = '0;
  logic [FW-1:0] pass_flags = '0;
  logic [4:0] rd1_idx, rd2_idx, rd3_idx, wr_idx;
  logic rd1_en, rd2_en, rd3_en, sr1_en, sr2_en, imm_en, wr_en, sw_en;
  logic [9:0] sr1_num, sr2_num, sw_num;
  logic [63:0] imm;
  logic rc_bit, rc_en, oe_bit, oe_en, lk_bit;
  logic [FW-1:0] flags_out;

  opsel_decode u_opsel_decode (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .insn(insn), .a_sel(a_sel), .b_sel(b_sel), .c_sel(c_sel), .d_sel(d_sel),
    .rc_mode(rc_mode), .op_class(op_class), .link_en(link_en),
    .pass_flags(pass_flags), .out_valid(out_valid), .out_ready(out_ready),
    .rd1_idx(rd1_idx), .rd1_en(rd1_en), .rd2_idx(rd2_idx), .rd2_en(rd2_en),
    .rd3_idx(rd3_idx), .rd3_en(rd3_en), .sr1_num(sr1_num), .sr1_en(sr1_en),
    .sr2_num(sr2_num), .sr2_en(sr2_en), .imm(imm), .imm_en(imm_en),
    .wr_idx(wr_idx), .wr_en(wr_en), .sw_num(sw_num), .sw_en(sw_en),
    .rc_bit(rc_bit), .rc_en(rc_en), .oe_bit(oe_bit), .oe_en(oe_en),
    .lk_bit(lk_bit), .flags_out(flags_out)
  );

  typedef struct {
    bit [4:0] rd1_idx, rd2_idx, rd3_idx, wr_idx;
    bit rd1_en, rd2_en, rd3_en, sr1_en, sr2_en, imm_en, wr_en, sw_en;
    bit [9:0] sr1_num, sr2_num, sw_num;
    bit [63:0] imm;
    bit rc_bit, oe_bit, lk_bit;
    bit [FW-1:0] flags;
    string imm_tag;
  } exp_t;

  exp_t sb_q[$];
  int checks = 0, errors = 0;
  int ready_mode = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // value of field bits s..e, MSB-first numbering
  function automatic bit [63:0] fld(bit [31:0] w, int s, int e);
    bit [63:0] v = '0;
    for (int n = s; n <= e; n++) v = {v[62:0], w[31-n]};
    return v;
  endfunction

  function automatic bit [63:0] sx(bit [63:0] v, int width);
    if (v[width-1]) return v | (~64'd0 << width);
    return v;
  endfunction

  function automatic exp_t model(bit [31:0] w, bit [1:0] a, bit [3:0] b, bit c,
                                 bit [1:0] d, bit [1:0] r, bit [2:0] cls, bit lnk,
                                 bit [FW-1:0] fl);
    exp_t x;
    bit [4:0] ra;
    ra = 5'(fld(w, 11, 15));
    x = '{default: 0};
    x.imm_tag = "R10";
    x.rd1_en  = (a == 2'd1) || (a == 2'd2 && ra != 0);
    x.rd1_idx = x.rd1_en ? ra : 5'd0;
    x.rd2_en  = (b == 4'd1);
    x.rd2_idx = x.rd2_en ? 5'(fld(w, 16, 20)) : 5'd0;
    x.rd3_en  = c;
    x.rd3_idx = c ? 5'(fld(w, 6, 10)) : 5'd0;
    if ((cls == 3'd1 || cls == 3'd2) && fld(w, 8, 8) == 0) begin
      x.sr1_en = 1; x.sr1_num = 10'd9;
    end else if (cls == 3'd3 || cls == 3'd4) begin
      x.sr1_en = 1; x.sr1_num = w[20:11];
    end
    if (b == 4'd12) begin
      x.sr2_en = 1; x.sr2_num = fld(w, 21, 21) != 0 ? 10'd9 : 10'd8;
    end
    x.imm_en = 1;
    case (b)
      4'd2: begin x.imm = fld(w, 16, 31); x.imm_tag = "R8"; end
      4'd3: begin x.imm = sx(fld(w, 16, 31), 16); x.imm_tag = "R8"; end
      4'd4: begin x.imm = fld(w, 16, 31) << 16; x.imm_tag = "R8"; end
      4'd5: begin x.imm = sx(fld(w, 16, 31) << 16, 32); x.imm_tag = "R8"; end
      4'd6: begin x.imm = sx(fld(w, 6, 29) << 2, 26); x.imm_tag = "R9"; end
      4'd7, 4'd8: begin x.imm = sx(fld(w, 16, 29) << 2, 16); x.imm_tag = "R9"; end
      4'd9: x.imm = '1;
      4'd10: x.imm = (fld(w, 30, 30) << 5) | fld(w, 16, 20);
      4'd11: x.imm = fld(w, 16, 20);
      default: x.imm_en = 0;
    endcase
    if (b == 4'd12) x.imm_tag = "R7";
    case (d)
      2'd1: begin x.wr_en = 1; x.wr_idx = 5'(fld(w, 6, 10)); end
      2'd2: begin x.wr_en = 1; x.wr_idx = ra; end
      2'd3: begin x.sw_en = 1; x.sw_num = w[20:11]; end
      default: ;
    endcase
    x.rc_bit = (r == 2'd1) || (r == 2'd2 && fld(w, 31, 31) != 0);
    x.oe_bit = fld(w, 21, 21) != 0;
    x.lk_bit = lnk && fld(w, 31, 31) != 0;
    x.flags  = fl;
    return x;
  endfunction

  task automatic send(bit [31:0] w, bit [1:0] a, bit [3:0] b, bit c, bit [1:0] d,
                      bit [1:0] r, bit [2:0] cls, bit lnk, bit [FW-1:0] fl);
    @(negedge clk);
    insn = w; a_sel = a; b_sel = b; c_sel = c; d_sel = d;
    rc_mode = r; op_class = cls; link_en = lnk; pass_flags = fl;
    in_valid = 1'b1;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    sb_q.push_back(model(w, a, b, c, d, r, cls, lnk, fl));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: sets back-pressure, then compares beats that are consumed
  initial begin
    forever begin
      @(negedge clk);
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = ($urandom % 4) != 0;
        default: out_ready = ($urandom % 2) != 0;
      endcase
      #1;
      if (rst_n && !done) begin
        chk(in_ready == (!out_valid || out_ready), "R1", "ready rule", in_ready, !out_valid || out_ready);
        if (out_valid && out_ready) begin
          if (sb_q.size() == 0) begin
            chk(0, "R1", "unexpected beat", 1, 0);
          end else begin
            exp_t e;
            e = sb_q.pop_front();
            chk(rd1_en == e.rd1_en && rd1_idx == e.rd1_idx, "R3", "read port 1", {rd1_en, rd1_idx}, {e.rd1_en, e.rd1_idx});
            chk(rd2_en == e.rd2_en && rd2_idx == e.rd2_idx, "R4", "read port 2", {rd2_en, rd2_idx}, {e.rd2_en, e.rd2_idx});
            chk(rd3_en == e.rd3_en && rd3_idx == e.rd3_idx, "R5", "read port 3", {rd3_en, rd3_idx}, {e.rd3_en, e.rd3_idx});
            chk(sr1_en == e.sr1_en && sr1_num == e.sr1_num, "R6", "special read 1", {sr1_en, sr1_num}, {e.sr1_en, e.sr1_num});
            chk(sr2_en == e.sr2_en && sr2_num == e.sr2_num, "R7", "special read 2", {sr2_en, sr2_num}, {e.sr2_en, e.sr2_num});
            chk(imm_en == e.imm_en, e.imm_tag, "imm enable", imm_en, e.imm_en);
            chk(imm == e.imm, e.imm_tag, "imm value", imm, e.imm);
            chk(wr_en == e.wr_en && wr_idx == e.wr_idx && sw_en == e.sw_en && sw_num == e.sw_num,
                "R11", "destination", {wr_en, wr_idx, sw_en, sw_num}, {e.wr_en, e.wr_idx, e.sw_en, e.sw_num});
            chk(rc_en && oe_en && rc_bit == e.rc_bit && oe_bit == e.oe_bit, "R12", "rc/oe",
                {rc_en, oe_en, rc_bit, oe_bit}, {2'b11, e.rc_bit, e.oe_bit});
            chk(lk_bit == e.lk_bit && flags_out == e.flags, "R13", "lk/flags",
                {lk_bit, flags_out}, {e.lk_bit, e.flags});
          end
        end
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    // R2: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid, "R2", "out_valid in reset", out_valid, 0);
    chk({rd1_en, rd2_en, rd3_en, sr1_en, sr2_en, imm_en, wr_en, sw_en, rc_en, oe_en} == '0,
        "R2", "enables in reset", {rd1_en, rd2_en, rd3_en, sr1_en, sr2_en, imm_en, wr_en, sw_en, rc_en, oe_en}, 0);
    chk(imm == '0 && flags_out == '0, "R2", "fields in reset", imm, 0);
    rst_n = 1'b1;

    // R3: read port 1 modes, RA zero and nonzero
    send(32'h0000_0000, 2'd2, 4'd0, 0, 2'd0, 2'd0, 3'd0, 0, '0);
    send(32'h001F_0000, 2'd2, 4'd0, 0, 2'd0, 2'd0, 3'd0, 0, '0);
    send(32'h0000_0000, 2'd1, 4'd0, 0, 2'd0, 2'd0, 3'd0, 0, '0);
    send(32'h0005_0000, 2'd3, 4'd0, 0, 2'd0, 2'd0, 3'd0, 0, '0);
    // R6: branch bit 8 clear/set, move special
    send(32'h0000_0000, 2'd0, 4'd0, 0, 2'd0, 2'd0, 3'd1, 0, '0);
    send(32'h0080_0000, 2'd0, 4'd0, 0, 2'd0, 2'd0, 3'd2, 0, '0);
    send(32'h0012_3400, 2'd0, 4'd0, 0, 2'd0, 2'd0, 3'd3, 0, '0);
    // R7: count vs link
    send(32'h0000_0400, 2'd0, 4'd12, 0, 2'd0, 2'd0, 3'd0, 0, '0);
    send(32'hFFFF_FBFF, 2'd0, 4'd12, 0, 2'd0, 2'd0, 3'd0, 0, '0);
    // R8 R9 R10: every operand code with sign set and clear
    for (int b = 0; b < 16; b++) begin
      send(32'hFFFF_8003, 2'd0, 4'(b), 1, 2'(b), 2'(b), 3'd0, 1, FW'(b));
      send(32'h0200_7FFC, 2'd1, 4'(b), 0, 2'(b + 1), 2'(b + 2), 3'd4, 0, FW'(~b));
    end
    // R11 R12 R13: destinations, rc modes, link
    for (int i = 0; i < 4; i++)
      send(32'h03E0_0401 ^ (32'h1 << (i * 7)), 2'd0, 4'd0, 0, 2'(i), 2'(i), 3'd0, i[0], FW'(i * 37));

    // R1: random traffic under back-pressure
    for (int m = 1; m < 3; m++) begin
      ready_mode = m;
      for (int i = 0; i < 200; i++) begin
        send($urandom, 2'($urandom), 4'($urandom), 1'($urandom), 2'($urandom),
             2'($urandom), 3'($urandom % 6), 1'($urandom), FW'($urandom));
        if (($urandom % 5) == 0) idle();
      end
    end
    idle();
    ready_mode = 0;
    for (int i = 0; i < 50 && sb_q.size() != 0; i++) @(negedge clk);
    #2;
    chk(sb_q.size() == 0, "R1", "all beats delivered", sb_q.size(), 0);
    repeat (2) @(negedge clk);
    #1;
    chk(!out_valid && in_ready, "R1", "idle after drain", {out_valid, in_ready}, 2'b01);
    summary();
  end
endmodule